// File: doc/BRIEF.md
# Rotating Register File with Stage Predicates

This block holds the loop-carried values of a software-pipelined loop whose code is a single kernel, with no separate prologue or epilogue. Each operation names a register by a small offset. The block turns that offset into a physical index by adding an iteration pointer, and the sum wraps modulo the file size. The storage itself never shifts. Only the pointer moves, so the same kernel code reaches a fresh set of registers on every pass.

The same loop-branch command that advances the pointer also updates a vector with one enable bit per pipeline stage. While source iterations remain, a 1 enters stage 0. Once the trip count has been used up, a 0 enters instead. Bits move one stage further on every branch and fall off after the last stage in use. A write names the stage it belongs to, and it is dropped when that stage's bit is clear. It is also dropped when its compare-produced condition bit is low. Pipeline fill and drain are handled this way without extra code. The loop-continue output stays high for as long as any stage is still enabled.

Top module: `rot_regfile`

## Requirements
- R1: After reset the iteration pointer is 0, every stage predicate bit is 0, loop-continue is 0 and every register reads as 0.
- R2: Each read port returns, in the same cycle, the register at physical index (offset + pointer) mod NREGS, where NREGS is a power of two.
- R3: A write commits at the clock edge to index (write offset + pointer) mod NREGS when the write enable, the condition bit and the predicate bit of the named stage are all 1. A read of that index in the same cycle still returns the old value, and the new value is visible from the next cycle.
- R4: A write whose condition bit is 0, or whose stage predicate bit is 0, or whose stage number is at or above the loop's stage count, leaves every register unchanged.
- R5: A loop branch while the loop is active (any predicate bit set) increments the pointer by 1 mod NREGS. A write issued in the same cycle uses the pointer and predicates from before the branch.
- R6: A loop start sets predicate bit 0 to (trip count != 0) and clears all other bits. It latches the stage count, with 0 treated as 1 and values above MAX_STAGES treated as MAX_STAGES. It leaves the pointer unchanged.
- R7: On each active branch, predicate bit k+1 takes the old bit k. Bit 0 becomes 1 if iterations that have not yet entered remain, and 0 otherwise. Bits at or above the stage count stay 0. Bit k of the stage predicate output is stage k.
- R8: Loop-continue is 1 exactly while any predicate bit is set. For trip count T >= 1 and effective stage count S, it is high for T+S-1 kernel passes after the start.
- R9: A trip count of 0 enables no stage, and loop-continue stays 0.
- R10: A branch while the loop is inactive changes neither the pointer nor the predicates.
- R11: A loop start and a branch in the same cycle act as the start alone; the pointer does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_start_i | input | 1 | Begin a new loop with the given trip and stage counts |
| trip_count_i | input | TRIP_W | Number of source iterations |
| stage_count_i | input | SC_W | Stages per iteration (0 taken as 1, clamped to MAX_STAGES) |
| branch_i | input | 1 | Loop-branch strobe, one per kernel pass |
| rd_a_off_i | input | IDX_W | Read port A register offset |
| rd_b_off_i | input | IDX_W | Read port B register offset |
| wr_en_i | input | 1 | Write request |
| wr_cond_i | input | 1 | Compare-produced condition qualifying the write |
| wr_stage_i | input | SIDX_W | Stage that issues the write |
| wr_off_i | input | IDX_W | Write register offset |
| wr_data_i | input | DATA_W | Write data |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_data_o | output | DATA_W | Read port B data |
| stage_pred_o | output | MAX_STAGES | Stage predicate vector, bit k is stage k |
| loop_cont_o | output | 1 | Loop still has passes to run |

## Verification
A register write and a loop branch can fall in the same cycle. The write must then land at the index formed with the pointer from before the branch, and it must be qualified by the predicates from before the shift. The bench issues a stage-0 write together with an active branch. It then reads with an offset one lower and expects the new data, and it checks that the predicate vector has moved on by one stage. A start together with a branch is provoked as well, and it is judged by unchanged read data at fixed offsets and a fresh single-bit predicate vector.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

    // Effective number of stages: zero means one, large values clamp.
    function automatic int unsigned eff_stages(int unsigned req, int unsigned max_s);
        if (req == 0) return 1;
        if (req > max_s) return max_s;
        return req;
    endfunction

    // Mask with the n lowest bits set.
    function automatic logic [31:0] low_ones(int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rrf_addr_xlate.sv
module rrf_addr_xlate #(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] off_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] phys_o
);
    // Sum truncated to IDX_W bits: wraps modulo the power-of-two file size.
    always_comb begin
        phys_o = off_i + ptr_i;
    end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int DATA_W = 16,
    parameter int NREGS  = 16,
    parameter int NRD    = 2
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         we_i,
    input  logic [$clog2(NREGS)-1:0]     waddr_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [NRD*$clog2(NREGS)-1:0] raddr_i,
    output logic [NRD*DATA_W-1:0]        rdata_o
);
    localparam int IDX_W = $clog2(NREGS);

    logic [DATA_W-1:0] mem_q [NREGS];
    logic [DATA_W-1:0] mem_d [NREGS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NREGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata_o[g*DATA_W +: DATA_W] = mem_q[raddr_i[g*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/rrf_stage_ctl.sv
module rrf_stage_ctl
    import rrf_pkg::*;
#(
    parameter int MAX_STAGES = 4,
    parameter int TRIP_W     = 8,
    parameter int IDX_W      = 4,
    parameter int SC_W       = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  start_i,
    input  logic [TRIP_W-1:0]     trip_i,
    input  logic [SC_W-1:0]       stages_i,
    input  logic                  branch_i,
    output logic [IDX_W-1:0]      icp_o,
    output logic [MAX_STAGES-1:0] pred_o,
    output logic [MAX_STAGES-1:0] mask_o
);
    typedef struct packed {
        logic [IDX_W-1:0]      icp;
        logic [MAX_STAGES-1:0] pred;
        logic [MAX_STAGES-1:0] mask;
        logic [TRIP_W-1:0]     remain;
    } ctl_st_t;

    ctl_st_t st_q, st_d;
    logic    active;
    logic    entering;
    logic [MAX_STAGES-1:0] new_mask;

    always_comb begin
        new_mask = MAX_STAGES'(low_ones(eff_stages(32'(stages_i), $unsigned(MAX_STAGES))));
        active   = |st_q.pred;
        entering = (st_q.remain != '0);
        st_d     = st_q;
        if (start_i) begin
            st_d.mask   = new_mask;
            st_d.pred   = MAX_STAGES'(trip_i != '0);
            st_d.remain = (trip_i != '0) ? trip_i - 1'b1 : '0;
        end else if (branch_i && active) begin
            st_d.icp  = st_q.icp + 1'b1;
            st_d.pred = ((st_q.pred << 1) | MAX_STAGES'(entering)) & st_q.mask;
            if (entering) begin
                st_d.remain = st_q.remain - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign icp_o  = st_q.icp;
    assign pred_o = st_q.pred;
    assign mask_o = st_q.mask;
endmodule

// File: rtl/rot_regfile.sv
module rot_regfile #(
    parameter int DATA_W     = 16,
    parameter int NREGS      = 16,
    parameter int MAX_STAGES = 4,
    parameter int TRIP_W     = 8,
    localparam int IDX_W     = $clog2(NREGS),
    localparam int SC_W      = $clog2(MAX_STAGES) + 2,
    localparam int SIDX_W    = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  loop_start_i,
    input  logic [TRIP_W-1:0]     trip_count_i,
    input  logic [SC_W-1:0]       stage_count_i,
    input  logic                  branch_i,
    input  logic [IDX_W-1:0]      rd_a_off_i,
    input  logic [IDX_W-1:0]      rd_b_off_i,
    input  logic                  wr_en_i,
    input  logic                  wr_cond_i,
    input  logic [SIDX_W-1:0]     wr_stage_i,
    input  logic [IDX_W-1:0]      wr_off_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    output logic [DATA_W-1:0]     rd_a_data_o,
    output logic [DATA_W-1:0]     rd_b_data_o,
    output logic [MAX_STAGES-1:0] stage_pred_o,
    output logic                  loop_cont_o
);
    localparam int NPORT = 3;  // two reads, one write

    logic [IDX_W-1:0]      icp_w;
    logic [MAX_STAGES-1:0] mask_w;
    logic [NPORT*IDX_W-1:0] offs_w;
    logic [NPORT*IDX_W-1:0] phys_w;
    logic [2*DATA_W-1:0]   rdata_w;
    logic                  stage_on;
    logic                  commit;

    rrf_stage_ctl #(
        .MAX_STAGES(MAX_STAGES),
        .TRIP_W    (TRIP_W),
        .IDX_W     (IDX_W),
        .SC_W      (SC_W)
    ) u_ctl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (loop_start_i),
        .trip_i  (trip_count_i),
        .stages_i(stage_count_i),
        .branch_i(branch_i),
        .icp_o   (icp_w),
        .pred_o  (stage_pred_o),
        .mask_o  (mask_w)
    );

    assign offs_w = {wr_off_i, rd_b_off_i, rd_a_off_i};

    for (genvar p = 0; p < NPORT; p++) begin : g_xlate
        rrf_addr_xlate #(.IDX_W(IDX_W)) u_xl (
            .off_i (offs_w[p*IDX_W +: IDX_W]),
            .ptr_i (icp_w),
            .phys_o(phys_w[p*IDX_W +: IDX_W])
        );
    end

    always_comb begin
        stage_on = 1'b0;
        for (int k = 0; k < MAX_STAGES; k++) begin
            if (int'(wr_stage_i) == k) stage_on = stage_pred_o[k];
        end
        commit = wr_en_i && wr_cond_i && stage_on;
    end

    rrf_storage #(
        .DATA_W(DATA_W),
        .NREGS (NREGS),
        .NRD   (2)
    ) u_store (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (commit),
        .waddr_i(phys_w[2*IDX_W +: IDX_W]),
        .wdata_i(wr_data_i),
        .raddr_i(phys_w[2*IDX_W-1:0]),
        .rdata_o(rdata_w)
    );

    assign rd_a_data_o = rdata_w[DATA_W-1:0];
    assign rd_b_data_o = rdata_w[2*DATA_W-1:DATA_W];
    assign loop_cont_o = |stage_pred_o;
endmodule

// File: rtl/rrf_chk.sv
module rrf_chk #(
    parameter int DATA_W     = 16,
    parameter int IDX_W      = 4,
    parameter int MAX_STAGES = 4,
    parameter int TRIP_W     = 8,
    parameter int SIDX_W     = 2
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  loop_start_i,
    input logic [TRIP_W-1:0]     trip_count_i,
    input logic                  branch_i,
    input logic                  wr_en_i,
    input logic                  wr_cond_i,
    input logic [SIDX_W-1:0]     wr_stage_i,
    input logic [IDX_W-1:0]      wr_off_i,
    input logic [IDX_W-1:0]      rd_a_off_i,
    input logic [DATA_W-1:0]     rd_a_data_o,
    input logic [MAX_STAGES-1:0] stage_pred_o,
    input logic                  loop_cont_o,
    input logic [IDX_W-1:0]      icp_w,
    input logic [MAX_STAGES-1:0] mask_w
);
    // R6
    start_pred_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loop_start_i |=> (stage_pred_o[0] == ($past(trip_count_i) != '0))
                         && ((stage_pred_o >> 1) == '0));

    // R9
    zero_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loop_start_i && trip_count_i == '0) |=> !loop_cont_o);

    // R5
    ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (branch_i && !loop_start_i && loop_cont_o) |=> icp_w == IDX_W'($past(icp_w) + 1'b1));

    // R10
    idle_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!loop_start_i && !loop_cont_o) |=> $stable(icp_w) && stage_pred_o == '0);

    // R7
    shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (branch_i && !loop_start_i && loop_cont_o) |=>
            (stage_pred_o & ~(($past(stage_pred_o) << 1) | MAX_STAGES'(1))) == '0);

    // R7
    mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage_pred_o & ~mask_w) == '0);

    // R7
    drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (branch_i && !loop_start_i && loop_cont_o && !stage_pred_o[0]) |=> !stage_pred_o[0]);

    // R11
    start_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (loop_start_i && branch_i) |=> $stable(icp_w));

    // R4
    null_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (!wr_cond_i || !stage_pred_o[wr_stage_i]) && !branch_i && !loop_start_i
         && rd_a_off_i == wr_off_i)
        |=> (!$stable(rd_a_off_i) || rd_a_data_o == $past(rd_a_data_o)));
endmodule

bind rot_regfile rrf_chk #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .MAX_STAGES(MAX_STAGES),
    .TRIP_W    (TRIP_W),
    .SIDX_W    (SIDX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .loop_start_i(loop_start_i),
    .trip_count_i(trip_count_i),
    .branch_i    (branch_i),
    .wr_en_i     (wr_en_i),
    .wr_cond_i   (wr_cond_i),
    .wr_stage_i  (wr_stage_i),
    .wr_off_i    (wr_off_i),
    .rd_a_off_i  (rd_a_off_i),
    .rd_a_data_o (rd_a_data_o),
    .stage_pred_o(stage_pred_o),
    .loop_cont_o (loop_cont_o),
    .icp_w       (icp_w),
    .mask_w      (mask_w)
);

// File: tb/rot_regfile_tb_top.sv
module rot_regfile_tb_top;
    localparam int DW  = 16;
    localparam int NR  = 16;
    localparam int MS  = 4;
    localparam int TW  = 8;
    localparam int IW  = $clog2(NR);
    localparam int SCW = $clog2(MS) + 2;
    localparam int SIW = $clog2(MS);

    // trip count, requested stage count, expected loop-continue passes (R8/R9)
    localparam int NSCN = 8;
    localparam int SCN [NSCN][3] = '{
        '{0, 3, 0}, '{1, 1, 1}, '{2, 4, 5}, '{5, 3, 7},
        '{3, 3, 5}, '{4, 9, 7}, '{3, 0, 3}, '{2, 3, 4}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [TW-1:0] trip = '0;
    logic [SCW-1:0] stc = '0;
    logic          branch = 1'b0;
    logic [IW-1:0] ra = '0, rb = '0, woff = '0;
    logic          wen = 1'b0, wcond = 1'b0;
    logic [SIW-1:0] wstg = '0;
    logic [DW-1:0] wdat = '0;
    logic [DW-1:0] rda, rdb;
    logic [MS-1:0] pred;
    logic          lcont;

    rot_regfile #(.DATA_W(DW), .NREGS(NR), .MAX_STAGES(MS), .TRIP_W(TW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .loop_start_i(start), .trip_count_i(trip),
        .stage_count_i(stc), .branch_i(branch), .rd_a_off_i(ra), .rd_b_off_i(rb),
        .wr_en_i(wen), .wr_cond_i(wcond), .wr_stage_i(wstg), .wr_off_i(woff),
        .wr_data_i(wdat), .rd_a_data_o(rda), .rd_b_data_o(rdb),
        .stage_pred_o(pred), .loop_cont_o(lcont)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int exp_icp = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [NR];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk_read(string tag, int off);
        ra = IW'(off);
        rb = IW'(off + 1);
        #1;
        chk(tag, 32'(rda), 32'(model[(off + exp_icp) % NR]));
        chk(tag, 32'(rdb), 32'(model[(off + 1 + exp_icp) % NR]));
    endtask

    function automatic logic [MS-1:0] exp_pred(int p, int t, int seff);
        logic [MS-1:0] v;
        v = '0;
        for (int k = 0; k < MS; k++) begin
            if (k < seff && p >= k && (p - k) < t) v[k] = 1'b1;
        end
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        int t, sc, np, seff, seen;
        logic [MS-1:0] ev;
        for (int i = 0; i < NR; i++) model[i] = '0;

        // R1: reset state
        tick(); tick();
        #1;
        chk("R1 pred", 32'(pred), 32'(0));
        chk("R1 loop_cont", 32'(lcont), 32'(0));
        rst_n = 1'b1;
        tick();
        chk_read("R1 regs zero", 0);
        chk_read("R1 regs zero hi", 14);

        // R6 R7 R8 R9 R10: scenario table
        for (int s = 0; s < NSCN; s++) begin
            t = SCN[s][0];
            sc = SCN[s][1];
            np = SCN[s][2];
            seff = (sc == 0) ? 1 : ((sc > MS) ? MS : sc);
            seen = 0;
            start = 1'b1; trip = TW'(t); stc = SCW'(sc);
            tick();
            start = 1'b0;
            for (int p = 0; p <= np + 1; p++) begin
                ev = exp_pred(p, t, seff);
                #1;
                chk($sformatf("R7 pred scn%0d pass%0d", s, p), 32'(pred), 32'(ev));
                chk($sformatf("R8 cont scn%0d pass%0d", s, p), 32'(lcont), 32'(ev != '0));
                if (lcont) seen++;
                branch = 1'b1;
                tick();
                branch = 1'b0;
                if (ev != '0) exp_icp++;
            end
            chk($sformatf("R8 R9 passes scn%0d", s), 32'(seen), 32'(np));
            chk_read($sformatf("R5 R10 ptr scn%0d", s), 3);
        end

        // R3: fill the file through stage 0 of a long loop
        start = 1'b1; trip = TW'(200); stc = SCW'(2);
        tick();
        start = 1'b0;
        #1 chk("R6 start pred", 32'(pred), 32'(1));
        for (int i = 0; i < NR; i++) begin
            wen = 1'b1; wcond = 1'b1; wstg = '0; woff = IW'(i); wdat = DW'(16'hA0 + i);
            tick();
            model[(i + exp_icp) % NR] = DW'(16'hA0 + i);
        end
        wen = 1'b0;
        chk_read("R3 R2 fill 0", 0);
        chk_read("R3 R2 fill 7", 7);
        chk_read("R2 wrap 15", 15);

        // R3: same-cycle read returns old value
        wen = 1'b1; wcond = 1'b1; wstg = '0; woff = IW'(5); wdat = 16'h5555; ra = IW'(5);
        #1 chk("R3 read old", 32'(rda), 32'(model[(5 + exp_icp) % NR]));
        tick();
        wen = 1'b0;
        model[(5 + exp_icp) % NR] = 16'h5555;
        chk_read("R3 read new", 5);

        // R4: stage beyond stage count, then condition low
        wen = 1'b1; wcond = 1'b1; wstg = SIW'(3); woff = IW'(6); wdat = 16'hDEAD;
        tick();
        wen = 1'b0;
        chk_read("R4 stage off", 6);
        wen = 1'b1; wcond = 1'b0; wstg = '0; woff = IW'(7); wdat = 16'hDEAD;
        tick();
        wen = 1'b0;
        chk_read("R4 cond low", 6);

        // R5: write and branch in the same cycle use the old pointer
        wen = 1'b1; wcond = 1'b1; wstg = '0; woff = IW'(2); wdat = 16'hBEEF; branch = 1'b1;
        tick();
        wen = 1'b0; branch = 1'b0;
        model[(2 + exp_icp) % NR] = 16'hBEEF;
        exp_icp++;
        #1 chk("R7 pred after branch", 32'(pred), 32'(3));
        chk_read("R5 write+branch", 1);
        chk_read("R2 wrap after branch", 15);

        // R3: write through stage 1 once enabled
        wen = 1'b1; wcond = 1'b1; wstg = SIW'(1); woff = IW'(9); wdat = 16'h1111;
        tick();
        wen = 1'b0;
        model[(9 + exp_icp) % NR] = 16'h1111;
        chk_read("R3 stage1 write", 9);

        // R11: start and branch together
        start = 1'b1; branch = 1'b1; trip = TW'(1); stc = SCW'(1);
        tick();
        start = 1'b0; branch = 1'b0;
        #1 chk("R11 pred", 32'(pred), 32'(1));
        chk_read("R11 ptr held", 4);
        branch = 1'b1;
        tick();
        branch = 1'b0;
        exp_icp++;
        #1 chk("R8 cont end", 32'(lcont), 32'(0));
        chk_read("R5 last branch", 4);

        // R10: branch while inactive; R4: write with all predicates clear
        branch = 1'b1;
        wen = 1'b1; wcond = 1'b1; wstg = '0; woff = IW'(4); wdat = 16'h7777;
        tick();
        branch = 1'b0; wen = 1'b0;
        #1 chk("R10 pred", 32'(pred), 32'(0));
        chk_read("R10 R4 idle", 4);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule